// File: doc/BRIEF.md
# Ping-Pong DMA Word Address Generator

This block produces the word addresses that a memory-card host controller's internal DMA engine places on its bus. Software programs two base addresses, a buffer size and a control word. When the data path becomes active, the block walks through one memory buffer, one 32-bit word per handshake. It works in either a single-buffer mode or a ping-pong mode. In ping-pong mode, a hardware-owned active-buffer bit flips at every buffer boundary and the address jumps to the other base. While the engine works through one buffer, software refills the other buffer and may move its base.

The bus itself is reduced to a `word_req`/`word_ack` pair. Each cycle in which both are high moves one word. A sticky buffer-complete flag marks every finished buffer. A sticky fault flag records a transfer error, which also stops address generation until the data path goes inactive.

The sequencer has four states. IDLE follows the configuration. RUN issues requests. HOLD waits without requesting. FAULT is the halted state after an error. The transitions are:
- IDLE to RUN on data-path start when enabled with a nonzero size.
- IDLE to HOLD on data-path start when enabled with a zero size.
- RUN to RUN on every word, including a ping-pong switch.
- RUN to HOLD on the last word of a single buffer.
- RUN or HOLD to FAULT on an error.
- Any state back to IDLE when the data path drops.

Top module: `dbuf_addr_gen`

## Requirements
- R1: After reset, every configuration field (enable, ping-pong mode, active-buffer bit, size, both bases) reads 0, `word_req` is low, and both flags are low.
- R2: Base writes store bits [31:2] of `cfg_wdata`. Bits [1:0] of both bases always read 0.
- R3: Writes to the control word (`cfg_sel`=0: bit0 enable, bit1 ping-pong mode, bit2 active buffer) and to the size (`cfg_sel`=1, bits [7:0]) take effect only while `dp_active` is low. At other times they leave the fields unchanged.
- R4: The bases are written with `cfg_sel`=2 (base 0) and `cfg_sel`=3 (base 1). While `dp_active` is low, both may be written. While it is high, base 0 accepts a write only when the active-buffer bit is 1, and base 1 only when it is 0.
- R5: A transfer starts on the first cycle with `dp_active` high while enable is 1 and size is nonzero. From the next cycle `word_req` is high and `word_addr` is base 0, or base 1 if ping-pong mode is on with the active-buffer bit at 1.
- R6: Each handshake (`word_req` and `word_ack` high, no error) advances `word_addr` by 4 within a buffer.
- R7: The size counts units of 8 words. In single-buffer mode, after size×8 handshakes `word_req` falls and stays low.
- R8: In ping-pong mode, the last handshake of a buffer flips the active-buffer bit and reloads `word_addr` with the other buffer's base. `word_req` stays high.
- R9: `btc_flag` sets on the last handshake of every buffer. It holds until a `btc_clr` strobe, and a set in the same cycle wins over the clear.
- R10: `xfer_err` outside IDLE sets `err_flag` and drops `word_req` until `dp_active` falls. Acks are then ignored. `err_flag` holds until `err_clr`.
- R11: With enable at 0, or with size 0, a high `dp_active` produces no request.
- R12: When `dp_active` falls, `word_req` is low from the next cycle and the active-buffer bit keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Field select: 0 control, 1 size, 2 base 0, 3 base 1 |
| cfg_wdata | input | 32 | Configuration write data |
| dp_active | input | 1 | Data path active level |
| word_ack | input | 1 | Bus accepted the current word |
| xfer_err | input | 1 | Transfer error from the bus |
| btc_clr | input | 1 | Clear strobe for the buffer-complete flag |
| err_clr | input | 1 | Clear strobe for the error flag |
| word_req | output | 1 | Word request to the bus |
| word_addr | output | 32 | Byte address of the current word |
| act_buf | output | 1 | Active-buffer bit |
| en_q | output | 1 | Enable readback |
| dbl_q | output | 1 | Ping-pong mode readback |
| size_q | output | 8 | Buffer size readback, units of 8 words |
| base0_q | output | 32 | Base 0 readback |
| base1_q | output | 32 | Base 1 readback |
| btc_flag | output | 1 | Sticky buffer-complete flag |
| err_flag | output | 1 | Sticky transfer-error flag |

## Verification
The scoreboard predicts every address across two ping-pong boundaries. A block that failed to jump to the other base, or that jumped a word early or late, would show a mismatched or unexpected handshake. Midway through, base 0 is rewritten while buffer 1 is active and base 1 is poked while locked. A broken lock would either lose the legal refill address or corrupt the buffer in flight. An error injected mid-buffer, followed by further acks, exposes a sequencer that keeps requesting after a fault. Zero size, a cleared enable, and a start from buffer 1 catch wrong start conditions and a wrong start base.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_HOLD  = 2'd2,
        ST_FAULT = 2'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_SIZE  = 2'd1,
        SEL_BASE0 = 2'd2,
        SEL_BASE1 = 2'd3
    } cfg_sel_e;

    localparam int unsigned BYTES_PER_WORD = 4;
endpackage

// File: rtl/dbuf_regs.sv
module dbuf_regs
    import dbuf_pkg::*;
#(
    parameter int AW  = 32,
    parameter int SZW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_sel,
    input  logic [31:0]    cfg_wdata,
    input  logic           dp_active,
    input  logic           act_toggle,
    output logic           en_q,
    output logic           dbl_q,
    output logic           act_q,
    output logic [SZW-1:0] size_q,
    output logic [AW-1:0]  base0_q,
    output logic [AW-1:0]  base1_q
);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(BYTES_PER_WORD - 1);

    logic wr_ctrl, wr_size, wr_b0, wr_b1;

    // Locking: control and size frozen while active; each base open
    // during a transfer only while the other buffer is the active one.
    always_comb begin
        wr_ctrl = cfg_we && (cfg_sel == SEL_CTRL)  && !dp_active;
        wr_size = cfg_we && (cfg_sel == SEL_SIZE)  && !dp_active;
        wr_b0   = cfg_we && (cfg_sel == SEL_BASE0) && (!dp_active || act_q);
        wr_b1   = cfg_we && (cfg_sel == SEL_BASE1) && (!dp_active || !act_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            dbl_q   <= 1'b0;
            act_q   <= 1'b0;
            size_q  <= '0;
            base0_q <= '0;
            base1_q <= '0;
        end else begin
            if (wr_ctrl) begin
                en_q  <= cfg_wdata[0];
                dbl_q <= cfg_wdata[1];
                act_q <= cfg_wdata[2];
            end else if (act_toggle) begin
                act_q <= ~act_q;
            end
            if (wr_size) size_q  <= cfg_wdata[SZW-1:0];
            if (wr_b0)   base0_q <= cfg_wdata[AW-1:0] & ALIGN_MASK;
            if (wr_b1)   base1_q <= cfg_wdata[AW-1:0] & ALIGN_MASK;
        end
    end
endmodule

// File: rtl/dbuf_seq.sv
module dbuf_seq
    import dbuf_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SZW        = 8,
    parameter int UNIT_WORDS = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dp_active,
    input  logic           en,
    input  logic           dbl,
    input  logic           act,
    input  logic [SZW-1:0] size,
    input  logic [AW-1:0]  base0,
    input  logic [AW-1:0]  base1,
    input  logic           word_ack,
    input  logic           xfer_err,
    output logic           word_req,
    output logic [AW-1:0]  word_addr,
    output logic           act_toggle,
    output logic           buf_done,
    output logic           fault_evt
);
    localparam int UNIT_LG = $clog2(UNIT_WORDS);
    localparam int CNTW    = SZW + UNIT_LG;

    seq_state_e      state_q, state_d;
    logic [CNTW-1:0] cnt_q;
    logic [CNTW-1:0] last_idx;
    logic            hs, at_last;
    logic [AW-1:0]   start_base, other_base;

    always_comb begin
        last_idx   = {size, UNIT_LG'(0)} - CNTW'(1);
        at_last    = (cnt_q == last_idx);
        hs         = word_req && word_ack && !xfer_err;
        start_base = (dbl && act) ? base1 : base0;
        other_base = act ? base0 : base1;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (dp_active && en)
                    state_d = (size != '0) ? ST_RUN : ST_HOLD;
            end
            ST_RUN: begin
                if (!dp_active)                 state_d = ST_IDLE;
                else if (xfer_err)              state_d = ST_FAULT;
                else if (hs && at_last && !dbl) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!dp_active)    state_d = ST_IDLE;
                else if (xfer_err) state_d = ST_FAULT;
            end
            ST_FAULT: begin
                if (!dp_active) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        word_req   = (state_q == ST_RUN);
        buf_done   = hs && at_last;
        act_toggle = hs && at_last && dbl;
        fault_evt  = xfer_err && (state_q != ST_IDLE);
    end

    // Address and word counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_addr <= '0;
            cnt_q     <= '0;
        end else if (state_q == ST_IDLE) begin
            word_addr <= start_base;
            cnt_q     <= '0;
        end else if (hs) begin
            if (at_last) begin
                cnt_q <= '0;
                if (dbl) word_addr <= other_base;
            end else begin
                cnt_q     <= cnt_q + CNTW'(1);
                word_addr <= word_addr + AW'(BYTES_PER_WORD);
            end
        end
    end
endmodule

// File: rtl/dbuf_flags.sv
module dbuf_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic buf_done,
    input  logic fault_evt,
    input  logic btc_clr,
    input  logic err_clr,
    output logic btc_flag,
    output logic err_flag
);
    // Set has priority over a clear strobe in the same cycle.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            btc_flag <= 1'b0;
            err_flag <= 1'b0;
        end else begin
            if (buf_done)     btc_flag <= 1'b1;
            else if (btc_clr) btc_flag <= 1'b0;
            if (fault_evt)    err_flag <= 1'b1;
            else if (err_clr) err_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/dbuf_addr_gen.sv
module dbuf_addr_gen
    import dbuf_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SZW        = 8,
    parameter int UNIT_WORDS = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_sel,
    input  logic [31:0]    cfg_wdata,
    input  logic           dp_active,
    input  logic           word_ack,
    input  logic           xfer_err,
    input  logic           btc_clr,
    input  logic           err_clr,
    output logic           word_req,
    output logic [AW-1:0]  word_addr,
    output logic           act_buf,
    output logic           en_q,
    output logic           dbl_q,
    output logic [SZW-1:0] size_q,
    output logic [AW-1:0]  base0_q,
    output logic [AW-1:0]  base1_q,
    output logic           btc_flag,
    output logic           err_flag
);
    logic act_toggle, buf_done, fault_evt;

    dbuf_regs #(.AW(AW), .SZW(SZW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_we     (cfg_we),
        .cfg_sel    (cfg_sel),
        .cfg_wdata  (cfg_wdata),
        .dp_active  (dp_active),
        .act_toggle (act_toggle),
        .en_q       (en_q),
        .dbl_q      (dbl_q),
        .act_q      (act_buf),
        .size_q     (size_q),
        .base0_q    (base0_q),
        .base1_q    (base1_q)
    );

    dbuf_seq #(.AW(AW), .SZW(SZW), .UNIT_WORDS(UNIT_WORDS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dp_active  (dp_active),
        .en         (en_q),
        .dbl        (dbl_q),
        .act        (act_buf),
        .size       (size_q),
        .base0      (base0_q),
        .base1      (base1_q),
        .word_ack   (word_ack),
        .xfer_err   (xfer_err),
        .word_req   (word_req),
        .word_addr  (word_addr),
        .act_toggle (act_toggle),
        .buf_done   (buf_done),
        .fault_evt  (fault_evt)
    );

    dbuf_flags u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .buf_done  (buf_done),
        .fault_evt (fault_evt),
        .btc_clr   (btc_clr),
        .err_clr   (err_clr),
        .btc_flag  (btc_flag),
        .err_flag  (err_flag)
    );
endmodule

// File: rtl/dbuf_chk.sv
module dbuf_chk #(
    parameter int AW  = 32,
    parameter int SZW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           dp_active,
    input logic           word_ack,
    input logic           xfer_err,
    input logic           btc_clr,
    input logic           word_req,
    input logic [AW-1:0]  word_addr,
    input logic           act_buf,
    input logic           en_q,
    input logic           dbl_q,
    input logic [SZW-1:0] size_q,
    input logic [AW-1:0]  base0_q,
    input logic [AW-1:0]  base1_q,
    input logic           btc_flag,
    input logic           err_flag
);
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (base0_q[1:0] == 2'b00) && (base1_q[1:0] == 2'b00));

    a_r3_ctrl_locked: assert property (@(posedge clk) disable iff (!rst_n)
        dp_active |=> ($stable(en_q) && $stable(dbl_q) && $stable(size_q)));

    a_r4_base0_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_active && !act_buf) |=> $stable(base0_q));

    a_r4_base1_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (dp_active && act_buf) |=> $stable(base1_q));

    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
        (word_req && word_ack && !xfer_err) |=>
            (!word_req || (act_buf != $past(act_buf)) ||
             (word_addr == $past(word_addr) + AW'(4))));

    a_r9_btc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (btc_flag && !btc_clr) |=> btc_flag);

    a_r10_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (word_req && xfer_err) |=> (!word_req && err_flag));

    a_r11_no_req_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !word_req);

    a_r12_idle_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !dp_active |=> !word_req);
endmodule

bind dbuf_addr_gen dbuf_chk #(.AW(AW), .SZW(SZW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dp_active (dp_active),
    .word_ack  (word_ack),
    .xfer_err  (xfer_err),
    .btc_clr   (btc_clr),
    .word_req  (word_req),
    .word_addr (word_addr),
    .act_buf   (act_buf),
    .en_q      (en_q),
    .dbl_q     (dbl_q),
    .size_q    (size_q),
    .base0_q   (base0_q),
    .base1_q   (base1_q),
    .btc_flag  (btc_flag),
    .err_flag  (err_flag)
);

// File: tb/sim_dbuf_addr_gen.sv
`timescale 1ns/1ps
module sim_dbuf_addr_gen;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic        dp_active = 1'b0;
    logic        word_ack = 1'b0;
    logic        xfer_err = 1'b0;
    logic        btc_clr = 1'b0;
    logic        err_clr = 1'b0;
    logic        word_req;
    logic [31:0] word_addr;
    logic        act_buf, en_q, dbl_q;
    logic [7:0]  size_q;
    logic [31:0] base0_q, base1_q;
    logic        btc_flag, err_flag;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_q[$];

    always #5 clk = ~clk;

    dbuf_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dp_active(dp_active), .word_ack(word_ack),
        .xfer_err(xfer_err), .btc_clr(btc_clr), .err_clr(err_clr),
        .word_req(word_req), .word_addr(word_addr), .act_buf(act_buf),
        .en_q(en_q), .dbl_q(dbl_q), .size_q(size_q), .base0_q(base0_q),
        .base1_q(base1_q), .btc_flag(btc_flag), .err_flag(err_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    // Monitor: every handshake is compared against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && word_req && word_ack && !xfer_err) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected handshake", word_addr, 32'hFFFF_FFFF);
            end else begin
                chk("R6 handshake address", word_addr, exp_q.pop_front());
            end
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(posedge clk) #1;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk) #1;
        cfg_we = 1'b0;
    endtask

    task automatic push_buf(input logic [31:0] base, input int words);
        for (int i = 0; i < words; i++) exp_q.push_back(base + 32'(4 * i));
    endtask

    task automatic drain(input string tag);
        int guard = 0;
        while (exp_q.size() != 0 && guard < 2000) begin
            @(posedge clk);
            guard++;
        end
        #1;
        word_ack = 1'b0;
        chk(tag, 32'(exp_q.size()), 32'd0);
        exp_q.delete();
    endtask

    task automatic pulse(ref logic sig);
        @(posedge clk) #1; sig = 1'b1;
        @(posedge clk) #1; sig = 1'b0;
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 word_req", 32'(word_req), 0);
        chk("R1 ctrl", {29'd0, act_buf, dbl_q, en_q}, 0);
        chk("R1 size", 32'(size_q), 0);
        chk("R1 base0", base0_q, 0);
        chk("R1 base1", base1_q, 0);
        chk("R1 flags", {30'd0, btc_flag, err_flag}, 0);

        // R2 alignment
        cfg_write(2'd2, 32'h0000_1003);
        cfg_write(2'd3, 32'h0000_2002);
        @(negedge clk);
        chk("R2 base0 low bits", base0_q, 32'h0000_1000);
        chk("R2 base1 low bits", base1_q, 32'h0000_2000);

        // R7 single buffer, 8 words
        cfg_write(2'd1, 32'd1);
        cfg_write(2'd0, 32'd1);
        push_buf(32'h1000, 8);
        @(posedge clk) #1; dp_active = 1'b1; word_ack = 1'b1;
        drain("R7 single buffer words");
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R7 req low after buffer", 32'(word_req), 0);
        chk("R9 btc set", 32'(btc_flag), 1);

        // R3 / R4 writes while active (act=0)
        cfg_write(2'd0, 32'd0);
        cfg_write(2'd1, 32'd5);
        cfg_write(2'd2, 32'h0000_7000);
        cfg_write(2'd3, 32'h0000_2040);
        @(negedge clk);
        chk("R3 ctrl unchanged", {29'd0, act_buf, dbl_q, en_q}, 32'd1);
        chk("R3 size unchanged", 32'(size_q), 32'd1);
        chk("R4 base0 locked", base0_q, 32'h0000_1000);
        chk("R4 base1 open", base1_q, 32'h0000_2040);

        // R12 drop
        @(posedge clk) #1; dp_active = 1'b0;
        @(negedge clk);
        chk("R12 req low", 32'(word_req), 0);
        chk("R9 btc still set", 32'(btc_flag), 1);
        pulse(btc_clr);
        @(negedge clk);
        chk("R9 btc cleared", 32'(btc_flag), 0);

        // R8 ping-pong across two boundaries with a refill of base 0
        cfg_write(2'd3, 32'h0000_2000);
        cfg_write(2'd0, 32'd3);
        push_buf(32'h1000, 8);
        push_buf(32'h2000, 8);
        push_buf(32'h3000, 8);
        @(posedge clk) #1; dp_active = 1'b1; word_ack = 1'b1;
        @(negedge clk);
        chk("R5 first address base0", word_addr, 32'h1000);
        while (act_buf !== 1'b1) @(negedge clk);
        cfg_write(2'd3, 32'h0000_5000);
        cfg_write(2'd2, 32'h0000_3000);
        drain("R8 ping-pong words");
        @(negedge clk);
        chk("R8 act after three buffers", 32'(act_buf), 1);
        chk("R8 req stays high", 32'(word_req), 1);
        chk("R4 base1 locked while active", base1_q, 32'h2000);
        chk("R4 base0 refilled", base0_q, 32'h3000);
        @(posedge clk) #1; dp_active = 1'b0;
        @(negedge clk);
        chk("R12 act retained", 32'(act_buf), 1);

        // R10 error mid buffer
        cfg_write(2'd0, 32'd1);
        cfg_write(2'd1, 32'd2);
        push_buf(32'h3000, 3);
        @(posedge clk) #1; dp_active = 1'b1; word_ack = 1'b1;
        drain("R10 words before error");
        @(posedge clk) #1; xfer_err = 1'b1;
        @(posedge clk) #1; xfer_err = 1'b0;
        @(negedge clk);
        chk("R10 req low after error", 32'(word_req), 0);
        chk("R10 err flag", 32'(err_flag), 1);
        @(posedge clk) #1; word_ack = 1'b1;
        repeat (4) @(posedge clk);
        #1 word_ack = 1'b0;
        @(negedge clk);
        chk("R10 still halted", 32'(word_req), 0);
        pulse(err_clr);
        @(negedge clk);
        chk("R10 err cleared", 32'(err_flag), 0);
        @(posedge clk) #1; dp_active = 1'b0;

        // R11 disabled and zero size
        cfg_write(2'd0, 32'd0);
        @(posedge clk) #1; dp_active = 1'b1; word_ack = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R11 no req when disabled", 32'(word_req), 0);
        @(posedge clk) #1; dp_active = 1'b0; word_ack = 1'b0;
        cfg_write(2'd0, 32'd1);
        cfg_write(2'd1, 32'd0);
        @(posedge clk) #1; dp_active = 1'b1; word_ack = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk("R11 no req with zero size", 32'(word_req), 0);
        @(posedge clk) #1; dp_active = 1'b0; word_ack = 1'b0;

        // R5 start from buffer 1
        cfg_write(2'd1, 32'd1);
        cfg_write(2'd0, 32'd7);
        push_buf(32'h2000, 2);
        @(posedge clk) #1; dp_active = 1'b1; word_ack = 1'b1;
        drain("R5 start from base1");
        @(negedge clk);
        chk("R5 act unchanged mid buffer", 32'(act_buf), 1);
        @(posedge clk) #1; dp_active = 1'b0;
        repeat (2) @(posedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule